// File: doc/BRIEF.md
# Interrupt Combiner and Sleep Wake Controller

This block gathers single-cycle event strobes from a set of interrupt sources into a bank of pending flags. It gates them with a per-source enable mask and a global interrupt enable, and produces one interrupt request line for the processor. Software acknowledges a pending event by writing a one to its bit.

The same block owns the processor's two low-power states. A halt request parks the core until any enabled source has a flag pending. A stop request parks it more deeply: only an enabled, pending keypad source can end it, and transfers by the DMA engine are held off for as long as it lasts.

While asleep, the block looks at its wake condition once per sleep step of `STEP_CLKS` clocks rather than every clock. It returns to the run state on the step boundary at which the condition is seen. The global interrupt enable plays no part in waking.

Top module: `intr_sleep_ctrl`

## Requirements
- R1: After reset, all pending flags, the enable mask and the global enable are zero, `pwr_state` is 0 (run), `run_en` and `dma_allow` are 1, and `cpu_irq` is 0.
- R2: `cpu_irq` is 1 exactly when the global enable is set and at least one source has both its mask bit and its pending flag set.
- R3: A strobe on `src_strobe[i]` sets pending flag i on the next clock. Writing with `ack_we` high clears every flag whose `ack_bits` bit is 1 and leaves the others. A strobe and an acknowledge on the same bit in the same cycle leave the flag set.
- R4: Writes to the global enable (`mie_we`) and to the mask (`mask_we`) take effect on the next clock; the values hold between writes.
- R5: In the run state, `halt_req` moves the block to the halted state (`pwr_state` = 1) and `stop_req` moves it to the stopped state (`pwr_state` = 2), both on the next clock. If both are high, stop wins.
- R6: The halted state returns to run when, at a step boundary, any source has both its mask bit and its pending flag set. This holds whatever the value of the global enable.
- R7: The stopped state returns to run only when, at a step boundary, the keypad source (index `KEY_IDX`, 12 by default) has both its mask bit and its pending flag set. No other source ends it.
- R8: The wake condition is sampled once per `STEP_CLKS` clocks (16 by default). Step boundaries fall 16, 32, 48, ... clocks after the clock edge that entered sleep, so the earliest return to run comes 16 edges after entry.
- R9: `halt_req` and `stop_req` have no effect while the block is halted or stopped.
- R10: `dma_allow` is 0 exactly while the block is in the stopped state.
- R11: `run_en` is 1 exactly while `pwr_state` is 0. On leaving either sleep state, `pwr_state` returns to 0 in the same clock that `run_en` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_strobe | input | NUM_SRC | One-cycle event pulses from the sources |
| mie_we | input | 1 | Write strobe for the global enable |
| mie_wdata | input | 1 | Value written to the global enable |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | NUM_SRC | Value written to the enable mask |
| ack_we | input | 1 | Write strobe for flag acknowledge |
| ack_bits | input | NUM_SRC | Write-one-to-clear pattern for pending flags |
| halt_req | input | 1 | Request to enter the halted state |
| stop_req | input | 1 | Request to enter the stopped state |
| cpu_irq | output | 1 | Interrupt request to the processor |
| run_en | output | 1 | Instruction execution allowed |
| pwr_state | output | 2 | 0 run, 1 halted, 2 stopped |
| dma_allow | output | 1 | DMA transfers permitted |
| pending | output | NUM_SRC | Current pending flags |

## Verification
Two functions can fall on the same flag bit in the same cycle: a source strobe setting it and a software acknowledge clearing it. The bench drives both together, on purpose in a directed case and by chance in the random phase. It expects the flag to stay set, because losing an event is worse than a redundant interrupt. A second coincidence is a strobe arriving in the very cycle of a step boundary. The registered flag is not yet visible there, so the bench's model expects the wake one full step later, and it compares the state cycle by cycle.

// File: rtl/intr_sleep_pkg.sv
package intr_sleep_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HALT = 2'd1,
    PS_STOP = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
  parameter int NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_strobe,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] ack_bits,
  output logic [NUM_SRC-1:0] flags_q
);
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] flags_d;
  logic               flag_upd;

  always_comb begin
    clr_mask = ack_we ? ack_bits : '0;
    // set has priority over clear on the same bit
    flags_d  = (flags_q & ~clr_mask) | src_strobe;
    flag_upd = ack_we | (|src_strobe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flag_upd) begin
      flags_q <= flags_d;
    end
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_strobe) |=> ((flags_q & $past(src_strobe)) == $past(src_strobe)));

  // R3
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((flags_q & $past(ack_bits & ~src_strobe)) == '0));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && (src_strobe == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/intr_enable_regs.sv
module intr_enable_regs #(
  parameter int NUM_SRC = 14,
  parameter int KEY_IDX = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mie_we,
  input  logic               mie_wdata,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic [NUM_SRC-1:0] flags,
  output logic               cpu_irq,
  output logic               any_wake,
  output logic               key_wake
);
  logic               mie_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_q <= 1'b0;
    end else if (mie_we) begin
      mie_q <= mie_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  always_comb begin
    live     = mask_q & flags;
    any_wake = |live;
    key_wake = live[KEY_IDX];
    cpu_irq  = mie_q & any_wake;
  end

  // R2
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mie_we && !mie_wdata) |=> !cpu_irq);

  // R4
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && (mask_wdata == '0)) |=> (!any_wake && !key_wake));
endmodule

// File: rtl/intr_sleep_fsm.sv
module intr_sleep_fsm
  import intr_sleep_pkg::*;
#(
  parameter int STEP_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       any_wake,
  input  logic       key_wake,
  output logic [1:0] pwr_state,
  output logic       run_en,
  output logic       dma_allow
);
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_CLKS - 1);

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  always_comb begin
    tick    = (state_q != PS_RUN) && (cnt_q == LAST_CNT);
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (stop_req)      state_d = PS_STOP;
        else if (halt_req) state_d = PS_HALT;
      end
      PS_HALT: if (tick && any_wake) state_d = PS_RUN;
      PS_STOP: if (tick && key_wake) state_d = PS_RUN;
      default: state_d = PS_RUN;
    endcase
    cnt_d = (state_q == PS_RUN || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    pwr_state = state_q;
    run_en    = (state_q == PS_RUN);
    dma_allow = (state_q != PS_STOP);
  end

  // R5
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_RUN && stop_req) |=> (state_q == PS_STOP));

  // R8
  no_early_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_RUN && !tick) |=> (state_q == $past(state_q)));

  // R6
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_HALT && tick && any_wake) |=> (state_q == PS_RUN));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STOP && tick && !key_wake) |=> (state_q == PS_STOP));
endmodule

// File: rtl/intr_sleep_ctrl.sv
module intr_sleep_ctrl #(
  parameter int NUM_SRC   = 14,
  parameter int KEY_IDX   = 12,
  parameter int STEP_CLKS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_strobe,
  input  logic               mie_we,
  input  logic               mie_wdata,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               ack_we,
  input  logic [NUM_SRC-1:0] ack_bits,
  input  logic               halt_req,
  input  logic               stop_req,
  output logic               cpu_irq,
  output logic               run_en,
  output logic [1:0]         pwr_state,
  output logic               dma_allow,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] flags;
  logic               any_wake;
  logic               key_wake;

  intr_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_strobe (src_strobe),
    .ack_we     (ack_we),
    .ack_bits   (ack_bits),
    .flags_q    (flags)
  );

  intr_enable_regs #(.NUM_SRC(NUM_SRC), .KEY_IDX(KEY_IDX)) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .mie_we     (mie_we),
    .mie_wdata  (mie_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .flags      (flags),
    .cpu_irq    (cpu_irq),
    .any_wake   (any_wake),
    .key_wake   (key_wake)
  );

  intr_sleep_fsm #(.STEP_CLKS(STEP_CLKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (halt_req),
    .stop_req  (stop_req),
    .any_wake  (any_wake),
    .key_wake  (key_wake),
    .pwr_state (pwr_state),
    .run_en    (run_en),
    .dma_allow (dma_allow)
  );

  assign pending = flags;

  // R10
  dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |-> !dma_allow);
endmodule

// File: tb/intr_sleep_ctrl_tb.sv
module intr_sleep_ctrl_tb;
  localparam int N   = 14;
  localparam int KEY = 12;
  localparam int STP = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_strobe = '0;
  logic         mie_we = 1'b0, mie_wdata = 1'b0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         ack_we = 1'b0;
  logic [N-1:0] ack_bits = '0;
  logic         halt_req = 1'b0, stop_req = 1'b0;
  logic         cpu_irq, run_en, dma_allow;
  logic [1:0]   pwr_state;
  logic [N-1:0] pending;

  intr_sleep_ctrl #(.NUM_SRC(N), .KEY_IDX(KEY), .STEP_CLKS(STP)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_strobe(src_strobe),
    .mie_we(mie_we), .mie_wdata(mie_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ack_we(ack_we), .ack_bits(ack_bits),
    .halt_req(halt_req), .stop_req(stop_req),
    .cpu_irq(cpu_irq), .run_en(run_en), .pwr_state(pwr_state),
    .dma_allow(dma_allow), .pending(pending)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0] m_flags = '0, m_mask = '0;
  logic         m_mie = 1'b0;
  logic [1:0]   m_state = 2'd0;
  int           m_cnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_next_state(logic [1:0] st, int cnt, logic [N-1:0] fl,
                                                logic [N-1:0] mk, logic h, logic s);
    logic t;
    t = (st != 2'd0) && (cnt == STP - 1);
    case (st)
      2'd0:    return s ? 2'd2 : (h ? 2'd1 : 2'd0);
      2'd1:    return (t && |(fl & mk)) ? 2'd0 : 2'd1;
      default: return (t && fl[KEY] && mk[KEY]) ? 2'd0 : 2'd2;
    endcase
  endfunction

  task automatic compare_all();
    check("R2 irq", cpu_irq, m_mie & |(m_mask & m_flags));
    check("R3 pending", pending, m_flags);
    check("R11 state", pwr_state, m_state);
    check("R11 run_en", run_en, m_state == 2'd0);
    check("R10 dma_allow", dma_allow, m_state != 2'd2);
  endtask

  // one clock: inputs already set by caller, cleared afterwards
  task automatic cycle();
    logic [N-1:0] nf, nm;
    logic         nmie, tk;
    logic [1:0]   ns;
    int           nc;
    nf   = (m_flags & ~(ack_we ? ack_bits : '0)) | src_strobe;
    nm   = mask_we ? mask_wdata : m_mask;
    nmie = mie_we ? mie_wdata : m_mie;
    tk   = (m_state != 2'd0) && (m_cnt == STP - 1);
    ns   = exp_next_state(m_state, m_cnt, m_flags, m_mask, halt_req, stop_req);
    nc   = (m_state == 2'd0 || tk) ? 0 : m_cnt + 1;
    @(posedge clk);
    #1;
    m_flags = nf; m_mask = nm; m_mie = nmie; m_state = ns; m_cnt = nc;
    compare_all();
    src_strobe = '0; mie_we = 0; mask_we = 0; ack_we = 0;
    halt_req = 0; stop_req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int entry;
    void'($urandom(32'h5eed1234));
    #9;
    // R1 reset state
    check("R1 pending", pending, 0);
    check("R1 irq", cpu_irq, 0);
    check("R1 state", pwr_state, 0);
    check("R1 run_en", run_en, 1);
    check("R1 dma_allow", dma_allow, 1);
    rst_n = 1'b1;
    @(negedge clk);
    idle(2);

    // R3 set, simultaneous set/clear, clear
    src_strobe = 14'h0008; cycle();
    check("R3 set", pending[3], 1);
    src_strobe = 14'h0008; ack_we = 1; ack_bits = 14'h0008; cycle();
    check("R3 set beats clear", pending[3], 1);
    ack_we = 1; ack_bits = 14'h0008; cycle();
    check("R3 w1c", pending[3], 0);

    // R4 / R2 enables
    src_strobe = 14'h0020; cycle();
    mask_we = 1; mask_wdata = 14'h0020; cycle();
    check("R4 mask alone no irq", cpu_irq, 0);
    mie_we = 1; mie_wdata = 1; cycle();
    check("R4 mie write irq", cpu_irq, 1);
    mie_we = 1; mie_wdata = 0; cycle();
    check("R2 mie off", cpu_irq, 0);

    // R6 halt wake with mie off, R8 exact step
    halt_req = 1; cycle();
    check("R5 halt entry", pwr_state, 1);
    for (int i = 1; i < STP; i++) begin
      cycle();
      check("R8 no early wake", pwr_state, 1);
    end
    cycle();
    check("R6 halt wake at step", pwr_state, 0);
    check("R11 run_en on wake", run_en, 1);

    // R7 stop ignores non-key source, R9 requests ignored
    ack_we = 1; ack_bits = '1; cycle();
    mask_we = 1; mask_wdata = 14'h0020 | (14'h1 << KEY); cycle();
    stop_req = 1; cycle();
    entry = 0;
    check("R10 dma blocked", dma_allow, 0);
    src_strobe = 14'h0020; cycle(); entry++;
    halt_req = 1; cycle(); entry++;
    check("R9 halt ignored in stop", pwr_state, 2);
    for (int i = 0; i < 40; i++) begin cycle(); entry++; end
    check("R7 other source no wake", pwr_state, 2);
    src_strobe = 14'h1 << KEY; cycle(); entry++;
    while (pwr_state != 0 && entry < 200) begin cycle(); entry++; end
    check("R7 key wake", pwr_state, 0);
    check("R8 wake on step multiple", entry % STP, 0);

    // R5 priority stop over halt
    halt_req = 1; stop_req = 1; cycle();
    check("R5 stop priority", pwr_state, 2);
    idle(STP);
    check("R7 key pending wakes stop", pwr_state, 0);

    // halt with nothing enabled stays asleep
    ack_we = 1; ack_bits = '1; cycle();
    halt_req = 1; cycle();
    idle(50);
    check("R6 halt stays without source", pwr_state, 1);
    stop_req = 1; cycle();
    check("R9 stop ignored in halt", pwr_state, 1);
    src_strobe = 14'h0020; cycle();
    idle(STP);
    check("R6 halt wakes on source", pwr_state, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      for (int b = 0; b < N; b++) src_strobe[b] = ($urandom % 24) == 0;
      if (($urandom % 8) == 0) begin ack_we = 1; ack_bits = N'($urandom); end
      if (($urandom % 16) == 0) begin
        mask_we = 1; mask_wdata = N'($urandom);
      end
      if (($urandom % 16) == 0) begin mie_we = 1; mie_wdata = 1'($urandom); end
      halt_req = ($urandom % 20) == 0;
      stop_req = ($urandom % 40) == 0;
      cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule